// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This block is the small controller that takes a clock generator from power-on reset to running outputs. After reset it parks and waits for an active-low power-good strobe from the board. Once that strobe has been low long enough to trust, the sequencer captures the configuration straps (a frequency select bit, a three-level mode select already decoded to low, mid or high, and an output-drive multiplier bit) exactly once, turns the oscillator and PLL on, waits a fixed lock time and then opens the clock outputs.

The power-good strobe is a one-shot sample qualifier. Before the sequencer leaves its wait state, the strobe passes through a synchronizer and a stability filter. After that, nothing on the strobe matters until the next power-on reset. The captured straps stay frozen and read back as status. A decoded operating mode (two normal modes, all-outputs-high-impedance, test) is derived from them.

The end-to-end latency is fixed by parameters: the synchronizer depth plus the stability window plus one sample cycle to reach oscillator enable, then the lock window. The integrator sizes these so that power-on to running outputs stays within 4 ms at the chosen clock.

Top module: `clkgen_pwrup_seq`

## Requirements
- R1: While `por_n` is low, and immediately after it falls, `osc_en` and `clk_out_en` are 0 and all captured strap outputs and `clk_mode` are 0.
- R2: The sequencer leaves its wait state only after the synchronized strobe has been low on `PG_STABLE_CYC` consecutive clock edges. A low pulse on `pgood_n` lasting `PG_STABLE_CYC-1` cycles leaves `osc_en` low.
- R3: When `pgood_n` is held low from a given cycle, `osc_en` first reads 1 after exactly `SYNC_STAGES + PG_STABLE_CYC + 1` rising edges.
- R4: The captured outputs `sel_lo_q`, `mode_lvl_q` and `drive_mult_q` equal the strap inputs present during the single sample cycle that precedes `osc_en` rising.
- R5: `clk_out_en` first reads 1 exactly `LOCK_CYC` rising edges after `osc_en` first reads 1, and it never rises while `osc_en` is low.
- R6: Once the sequencer has left its wait state, any later activity on `pgood_n` has no effect on `osc_en`, `clk_out_en` or the captured straps until `por_n` is asserted again.
- R7: Changes on the strap inputs after the capture leave the captured outputs unchanged.
- R8: `clk_mode` decodes the captured straps. Level code 2'b01 is mid, 2'b00 is low, and 2'b10 and 2'b11 are high. Low gives 0 and high gives 1. Mid with `sel_lo_q`=0 gives 2 (outputs high impedance). Mid with `sel_lo_q`=1 gives 3 (test).
- R9: Asserting `por_n` low at any point of the sequence returns it to waiting and clears the capture. A fresh sequence then captures new strap values.
- R10: Once raised, `osc_en` and `clk_out_en` stay high until `por_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pgood_n | input | 1 | Power-good sample strobe, active low, asynchronous to clk |
| sel_lo | input | 1 | Frequency select strap |
| sel_mode_lvl | input | 2 | Decoded three-level mode strap (00 low, 01 mid, 1x high) |
| drive_mult | input | 1 | Output current multiplier strap |
| sel_lo_q | output | 1 | Captured frequency select |
| mode_lvl_q | output | 2 | Captured mode strap level |
| drive_mult_q | output | 1 | Captured multiplier strap |
| clk_mode | output | 2 | Decoded operating mode from captured straps |
| osc_en | output | 1 | Oscillator and PLL enable |
| clk_out_en | output | 1 | Clock output enable |

## Verification
The hardest case to reach from the ports is the exact edge of the stability filter. The strobe must stay low for one cycle fewer than the window and be rejected, or for exactly the window and be accepted, and then be released while the sequencer is still inside its sample path. The stimulus drives such pulses cycle by cycle at the falling clock edge, together with random glitch trains shorter than the window and random strap noise. After the capture it toggles the strobe and straps freely, so the rejection and one-shot behaviour are both seen from the outputs.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_VCO    = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_t;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;

  localparam logic [1:0] MODE_NORM_LO = 2'd0;
  localparam logic [1:0] MODE_NORM_HI = 2'd1;
  localparam logic [1:0] MODE_HIZ     = 2'd2;
  localparam logic [1:0] MODE_TEST    = 2'd3;

  // Operating mode from captured straps; any code other than low/mid counts as high.
  function automatic logic [1:0] decode_mode(input logic sel, input logic [1:0] lvl);
    logic [1:0] m;
    if (lvl == LVL_MID)      m = sel ? MODE_TEST : MODE_HIZ;
    else if (lvl == LVL_LOW) m = MODE_NORM_LO;
    else                     m = MODE_NORM_HI;
    return m;
  endfunction

  // Edges from the strobe going low to the oscillator enable being visible.
  function automatic int unsigned strobe_to_osc(input int unsigned stages,
                                                input int unsigned stable);
    return stages + stable + 1;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES:0] tap;
  assign tap[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap[i+1] <= RST_VAL;
      else        tap[i+1] <= tap[i];
    end
  end

  assign q = tap[STAGES];
endmodule

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || expired)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwrseq_strap_latch.sv
module pwrseq_strap_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       sel_d,
  input  logic [1:0] lvl_d,
  input  logic       mult_d,
  output logic       sel_q,
  output logic [1:0] lvl_q,
  output logic       mult_q,
  output logic       held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      lvl_q  <= 2'b00;
      mult_q <= 1'b0;
      held   <= 1'b0;
    end else if (capture && !held) begin
      sel_q  <= sel_d;
      lvl_q  <= lvl_d;
      mult_q <= mult_d;
      held   <= 1'b1;
    end
  end

  // R7
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable({sel_q, lvl_q, mult_q}));

  // R4
  strap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> ({sel_q, lvl_q, mult_q} == $past({sel_d, lvl_d, mult_d})));
endmodule

// File: rtl/clkgen_pwrup_seq.sv
module clkgen_pwrup_seq #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned PG_STABLE_CYC = 4,
  parameter int unsigned LOCK_CYC      = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pgood_n,
  input  logic       sel_lo,
  input  logic [1:0] sel_mode_lvl,
  input  logic       drive_mult,
  output logic       sel_lo_q,
  output logic [1:0] mode_lvl_q,
  output logic       drive_mult_q,
  output logic [1:0] clk_mode,
  output logic       osc_en,
  output logic       clk_out_en
);
  import pwrseq_pkg::*;

  seq_state_t state, state_nx;
  logic pg_sync_n, pg_low;
  logic filt_run, filt_done;
  logic lock_run, lock_done;
  logic capture, strap_held;

  pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(por_n), .d(pgood_n), .q(pg_sync_n)
  );
  assign pg_low = ~pg_sync_n;

  assign filt_run = (state == ST_WAIT) && pg_low;
  pwrseq_delay #(.CYCLES(PG_STABLE_CYC)) u_filter (
    .clk(clk), .rst_n(por_n), .run(filt_run), .expired(filt_done)
  );

  assign lock_run = (state == ST_VCO);
  pwrseq_delay #(.CYCLES(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(por_n), .run(lock_run), .expired(lock_done)
  );

  assign capture = (state == ST_SAMPLE);
  pwrseq_strap_latch u_straps (
    .clk(clk), .rst_n(por_n), .capture(capture),
    .sel_d(sel_lo), .lvl_d(sel_mode_lvl), .mult_d(drive_mult),
    .sel_q(sel_lo_q), .lvl_q(mode_lvl_q), .mult_q(drive_mult_q),
    .held(strap_held)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_WAIT:   if (filt_done) state_nx = ST_SAMPLE;
      ST_SAMPLE: state_nx = ST_VCO;
      ST_VCO:    if (lock_done) state_nx = ST_RUN;
      ST_RUN:    state_nx = ST_RUN;
      default:   state_nx = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state <= ST_WAIT;
    else        state <= state_nx;
  end

  assign osc_en     = (state == ST_VCO) || (state == ST_RUN);
  assign clk_out_en = (state == ST_RUN);
  assign clk_mode   = decode_mode(sel_lo_q, mode_lvl_q);

  // R2
  pg_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
    filt_done |-> $past(pg_low));

  // R6
  no_rearm_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state != ST_WAIT) |=> (state != ST_WAIT));

  // R10
  osc_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    osc_en |=> osc_en);

  // R5
  lock_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(clk_out_en) |-> ($past(osc_en) && $past(lock_done)));

  // R4
  strap_before_osc_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(osc_en) |-> strap_held);
endmodule

// File: tb/clkgen_pwrup_seq_tb_top.sv
module clkgen_pwrup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_N = 2;
  localparam int PG_N   = 4;
  localparam int LOCK_N = 16;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pgood_n = 1'b1;
  logic sel_lo = 1'b0;
  logic [1:0] sel_mode_lvl = 2'b00;
  logic drive_mult = 1'b0;
  logic sel_lo_q, drive_mult_q, osc_en, clk_out_en;
  logic [1:0] mode_lvl_q, clk_mode;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_pwrup_seq #(.SYNC_STAGES(SYNC_N), .PG_STABLE_CYC(PG_N), .LOCK_CYC(LOCK_N)) dut_i (
    .clk(clk), .por_n(por_n), .pgood_n(pgood_n), .sel_lo(sel_lo),
    .sel_mode_lvl(sel_mode_lvl), .drive_mult(drive_mult),
    .sel_lo_q(sel_lo_q), .mode_lvl_q(mode_lvl_q), .drive_mult_q(drive_mult_q),
    .clk_mode(clk_mode), .osc_en(osc_en), .clk_out_en(clk_out_en)
  );

  // Two flops of synchronization, the filter window, then one sample cycle.
  function automatic int exp_osc_edges();
    return SYNC_N + PG_N + 1;
  endfunction

  function automatic int exp_mode(input logic s, input logic [1:0] lvl);
    case (lvl)
      2'b01:   return s ? 3 : 2;
      2'b00:   return 0;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic apply_por();
    @(negedge clk);
    por_n = 1'b0;
    pgood_n = 1'b1;
    #1;
    // R1
    chk(osc_en == 0 && clk_out_en == 0, "R1", "enables in reset",
        {osc_en, clk_out_en}, 0);
    chk({sel_lo_q, mode_lvl_q, drive_mult_q, clk_mode} == 0, "R1", "captures in reset",
        int'({sel_lo_q, mode_lvl_q, drive_mult_q, clk_mode}), 0);
    @(negedge clk);
    por_n = 1'b1;
  endtask

  // Hold strobe low from a falling edge, optionally release after rel edges.
  task automatic strobe_and_measure(input int rel, output int e_osc, output int e_out);
    int e = 0;
    pgood_n = 1'b0;
    while (!osc_en && e < 200) begin
      @(negedge clk);
      e++;
      if (rel > 0 && e == rel) pgood_n = 1'b1;
    end
    e_osc = e;
    e = 0;
    while (!clk_out_en && e < 200) begin
      @(negedge clk);
      e++;
    end
    e_out = e;
  endtask

  task automatic check_capture(input logic s, input logic [1:0] lvl, input logic m);
    // R4
    chk({sel_lo_q, mode_lvl_q, drive_mult_q} == {s, lvl, m}, "R4", "captured straps",
        int'({sel_lo_q, mode_lvl_q, drive_mult_q}), int'({s, lvl, m}));
    // R8
    chk(int'(clk_mode) == exp_mode(s, lvl), "R8", "mode decode",
        int'(clk_mode), exp_mode(s, lvl));
  endtask

  task automatic full_run(input logic s, input logic [1:0] lvl, input logic m);
    int eo, eu;
    sel_lo = s; sel_mode_lvl = lvl; drive_mult = m;
    strobe_and_measure(0, eo, eu);
    // R3
    chk(eo == exp_osc_edges(), "R3", "strobe to osc_en edges", eo, exp_osc_edges());
    // R5
    chk(eu == LOCK_N, "R5", "osc_en to clk_out_en edges", eu, LOCK_N);
    check_capture(s, lvl, m);
  endtask

  initial begin
    int eo, eu;
    logic s, m;
    logic [1:0] lvl;
    void'($urandom(32'h5EC0_0D1E));

    apply_por();
    repeat (3) @(negedge clk);
    // R1: no strobe yet, so nothing starts
    chk(osc_en == 0, "R1", "idle after reset", osc_en, 0);

    // R2: one cycle short of the window is rejected
    pgood_n = 1'b0;
    repeat (PG_N - 1) @(negedge clk);
    pgood_n = 1'b1;
    repeat (PG_N + 8) @(negedge clk);
    chk(osc_en == 0, "R2", "short strobe rejected", osc_en, 0);

    // R2/R3/R6: exactly the window, then released inside the sample path
    sel_lo = 1'b1; sel_mode_lvl = 2'b01; drive_mult = 1'b1;
    strobe_and_measure(PG_N, eo, eu);
    chk(eo == exp_osc_edges(), "R2", "window-length strobe accepted", eo, exp_osc_edges());
    chk(eu == LOCK_N, "R6", "released strobe ignored", eu, LOCK_N);
    check_capture(1'b1, 2'b01, 1'b1);

    // R8: every strap combination
    for (int k = 0; k < 8; k++) begin
      apply_por();
      full_run(k[0], k[2:1], ~k[0]);
    end

    // R9: reset during the lock wait, then a fresh capture
    apply_por();
    sel_lo = 1'b0; sel_mode_lvl = 2'b10; drive_mult = 1'b1;
    pgood_n = 1'b0;
    while (!osc_en) @(negedge clk);
    repeat (3) @(negedge clk);
    apply_por();
    chk(osc_en == 0 && clk_out_en == 0, "R9", "reset mid-lock clears enables",
        {osc_en, clk_out_en}, 0);
    full_run(1'b1, 2'b00, 1'b0);

    // Random runs: glitch trains, strap noise, then post-capture chaos
    for (int it = 0; it < 25; it++) begin
      apply_por();
      for (int g = 0; g < 1 + int'($urandom_range(3)); g++) begin
        sel_lo = 1'($urandom); sel_mode_lvl = 2'($urandom); drive_mult = 1'($urandom);
        pgood_n = 1'b0;
        repeat (1 + $urandom_range(PG_N - 2)) @(negedge clk);
        pgood_n = 1'b1;
        repeat (1 + $urandom_range(4)) @(negedge clk);
      end
      repeat (SYNC_N + PG_N) @(negedge clk);
      chk(osc_en == 0, "R2", "glitch train rejected", osc_en, 0);
      s = 1'($urandom); lvl = 2'($urandom); m = 1'($urandom);
      full_run(s, lvl, m);
      for (int c = 0; c < 30; c++) begin
        pgood_n = 1'($urandom);
        sel_lo = 1'($urandom); sel_mode_lvl = 2'($urandom); drive_mult = 1'($urandom);
        @(negedge clk);
        // R10 / R6
        chk(osc_en && clk_out_en, "R10", "enables held", {osc_en, clk_out_en}, 3);
        // R7
        chk({sel_lo_q, mode_lvl_q, drive_mult_q} == {s, lvl, m}, "R7", "capture frozen",
            int'({sel_lo_q, mode_lvl_q, drive_mult_q}), int'({s, lvl, m}));
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule